// File: doc/BRIEF.md
# Parallel Supply Switch Count Controller

This block regulates a core supply rail that is fed from a higher rail through a bank of identical parallel switches. On every clock it samples the core-voltage code and the target voltage code and forms their difference as an error. From the delayed error and the delayed change in that error it computes a correction, rounds it to a whole number of switches and adds it to an earlier count. The result is held between one and the number of switches, so the core rail is never left floating.

Two signed fixed-point gains set how strongly the loop reacts to the error and to its change. Two parameters add fixed sample delays: one on the count feedback path and one on the error path. The count goes out both as a binary number and as a thermometer-coded enable vector that drives the switch gates directly.

Top module: `supply_hop_ctrl`

## Requirements
- R1: While reset is low and just after it is released, the count is 1, only enable bit 0 is set, and every stored past error is zero.
- R2: The count is always at least 1 and at most NUM_SW (default 16).
- R3: On each clock edge k the count becomes clamp(u[k-FB_DLY] + round(gainDiff*(e[k-D] - e[k-D-1]) + gainErr*e[k-D])), where D = FB_DLY + ERR_DLY (defaults 1 and 1) and u[j] is the count after edge j.
- R4: The error sample e[k] is vRef minus vCore, taken at edge k. Both codes are unsigned, and the difference is signed and one bit wider, so it never wraps.
- R5: The gains are GAIN_W-bit (default 12) two's complement values with 8 fractional bits. The correction is rounded to the nearest integer, and a value exactly halfway is rounded away from zero (+1.5 becomes +2, -1.5 becomes -2).
- R6: Enable bit i is 1 exactly when i is less than the count.
- R7: An error sample taken at edge k first changes the count at edge k+D.
- R8: A sum below 1 gives a count of exactly 1, whatever its magnitude.
- R9: A sum above NUM_SW gives a count of exactly NUM_SW, whatever its magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vCore | input | V_W | Sampled core-voltage code, unsigned |
| vRef | input | V_W | Target voltage code, unsigned |
| gainDiff | input | GAIN_W | Gain on the change in error, signed, 8 fractional bits |
| gainErr | input | GAIN_W | Gain on the error, signed, 8 fractional bits |
| switchCount | output | $clog2(NUM_SW+1) | Number of switches turned on |
| switchEn | output | NUM_SW | Thermometer-coded switch enables |

## Verification
On every cycle the assertions check that the count stays within its range and that the enable vector is a thermometer code whose population equals the count. They also check that an out-of-range sum lands exactly on the floor or the ceiling, and that a correction rounding to zero leaves the delayed count unchanged. Only the bench scenarios can show the arithmetic itself: the rounding of halfway values, the sign of the error, the latency of an error step through both delays, and the one-off effect of the difference term. The bench checks these against its own model of the update rule.

// File: rtl/supply_hop_pkg.sv
package supply_hop_pkg;

  // Clamp choice sent from the control to the datapath; exactly one is set.
  typedef struct packed {
    logic takeFloor;
    logic takeCeil;
    logic takeCand;
  } clampSel_t;

endpackage

// File: rtl/supply_hop_control.sv
module supply_hop_control
  import supply_hop_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      belowMin,
  input  logic      aboveMax,
  output clampSel_t sel
);

  always_comb begin
    sel = '0;
    if (belowMin)      sel.takeFloor = 1'b1;
    else if (aboveMax) sel.takeCeil  = 1'b1;
    else               sel.takeCand  = 1'b1;
  end

  // R2: the datapath always gets exactly one clamp choice
  a_r2_one_choice: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({sel.takeFloor, sel.takeCeil, sel.takeCand}));

endmodule

// File: rtl/supply_hop_datapath.sv
module supply_hop_datapath
  import supply_hop_pkg::*;
#(
  parameter int NUM_SW  = 16,
  parameter int V_W     = 10,
  parameter int GAIN_W  = 12,
  parameter int FRAC    = 8,
  parameter int FB_DLY  = 1,
  parameter int ERR_DLY = 1,
  localparam int CW     = $clog2(NUM_SW + 1)
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [V_W-1:0]           vCore,
  input  logic [V_W-1:0]           vRef,
  input  logic signed [GAIN_W-1:0] gainDiff,
  input  logic signed [GAIN_W-1:0] gainErr,
  input  clampSel_t                sel,
  output logic                     belowMin,
  output logic                     aboveMax,
  output logic [CW-1:0]            count
);

  localparam int D  = FB_DLY + ERR_DLY;
  localparam int EW = V_W + 1;
  localparam int DW = V_W + 2;
  localparam int PW = DW + GAIN_W;
  localparam int SW = PW + 1;
  localparam int RW = SW + 1;
  localparam int XW = RW + 1;
  localparam logic [SW-1:0] HALF = SW'(1) << (FRAC - 1);
  localparam logic signed [XW-1:0] MIN_C = XW'(1);
  localparam logic signed [XW-1:0] MAX_C = XW'(NUM_SW);

  // Error sample and its history: errReg[j] holds e[k-1-j]
  logic signed [EW-1:0] eNow;
  logic signed [EW-1:0] errReg [0:D];
  logic signed [EW-1:0] eTap   [0:D+1];

  assign eNow = $signed({1'b0, vRef}) - $signed({1'b0, vCore});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j <= D; j++) errReg[j] <= '0;
    end else begin
      errReg[0] <= eNow;
      for (int j = 1; j <= D; j++) errReg[j] <= errReg[j-1];
    end
  end

  always_comb begin
    eTap[0] = eNow;
    for (int j = 1; j <= D + 1; j++) eTap[j] = errReg[j-1];
  end

  // Control law terms
  logic signed [EW-1:0] eA, eB;
  logic signed [DW-1:0] dE;
  logic signed [PW-1:0] prodD, prodE;
  logic signed [SW-1:0] sumT;
  logic        [SW-1:0] mag, rMag;
  logic signed [RW-1:0] rounded;

  assign eA    = eTap[D];
  assign eB    = eTap[D+1];
  assign dE    = DW'(eA) - DW'(eB);
  assign prodD = PW'(dE) * PW'(gainDiff);
  assign prodE = PW'(eA) * PW'(gainErr);
  assign sumT  = SW'(prodD) + SW'(prodE);

  // Round half away from zero on the magnitude, then restore the sign
  assign mag     = sumT[SW-1] ? SW'(-sumT) : SW'(sumT);
  assign rMag    = (mag + HALF) >> FRAC;
  assign rounded = sumT[SW-1] ? -$signed({1'b0, rMag}) : $signed({1'b0, rMag});

  // Count history: uHist[j] holds u[k-1-j]
  logic [CW-1:0] uHist [0:FB_DLY-1];
  logic [CW-1:0] uOld;
  logic signed [XW-1:0] cand;
  logic [CW-1:0] nextCount;

  assign uOld     = uHist[FB_DLY-1];
  assign cand     = XW'(rounded) + $signed({{(XW-CW){1'b0}}, uOld});
  assign belowMin = cand < MIN_C;
  assign aboveMax = cand > MAX_C;

  always_comb begin
    nextCount = cand[CW-1:0];
    if (sel.takeFloor)     nextCount = CW'(1);
    else if (sel.takeCeil) nextCount = CW'(NUM_SW);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < FB_DLY; j++) uHist[j] <= CW'(1);
    end else begin
      uHist[0] <= nextCount;
      for (int j = 1; j < FB_DLY; j++) uHist[j] <= uHist[j-1];
    end
  end

  assign count = uHist[0];

  // R8: a sum under the floor lands exactly on one switch
  a_r8_floor: assert property (@(posedge clk) disable iff (!rstN)
    belowMin |=> (count == CW'(1)));

  // R9: a sum over the ceiling lands exactly on all switches
  a_r9_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    aboveMax |=> (count == CW'(NUM_SW)));

  // R3: a correction that rounds to zero repeats the delayed count
  a_r3_zero_term: assert property (@(posedge clk) disable iff (!rstN)
    (rounded == '0) |=> (count == $past(uOld)));

endmodule

// File: rtl/supply_hop_thermo.sv
module supply_hop_thermo #(
  parameter int NUM_SW = 16,
  localparam int CW    = $clog2(NUM_SW + 1)
)(
  input  logic [CW-1:0]     count,
  output logic [NUM_SW-1:0] en
);

  for (genvar i = 0; i < NUM_SW; i++) begin : g_bit
    assign en[i] = count > CW'(i);
  end

endmodule

// File: rtl/supply_hop_ctrl.sv
module supply_hop_ctrl
  import supply_hop_pkg::*;
#(
  parameter int NUM_SW  = 16,
  parameter int V_W     = 10,
  parameter int GAIN_W  = 12,
  parameter int FRAC    = 8,
  parameter int FB_DLY  = 1,
  parameter int ERR_DLY = 1,
  localparam int CW     = $clog2(NUM_SW + 1)
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [V_W-1:0]           vCore,
  input  logic [V_W-1:0]           vRef,
  input  logic signed [GAIN_W-1:0] gainDiff,
  input  logic signed [GAIN_W-1:0] gainErr,
  output logic [CW-1:0]            switchCount,
  output logic [NUM_SW-1:0]        switchEn
);

  clampSel_t sel;
  logic belowMin, aboveMax;

  supply_hop_datapath #(
    .NUM_SW(NUM_SW), .V_W(V_W), .GAIN_W(GAIN_W), .FRAC(FRAC),
    .FB_DLY(FB_DLY), .ERR_DLY(ERR_DLY)
  ) dp (
    .clk(clk), .rstN(rstN), .vCore(vCore), .vRef(vRef),
    .gainDiff(gainDiff), .gainErr(gainErr), .sel(sel),
    .belowMin(belowMin), .aboveMax(aboveMax), .count(switchCount)
  );

  supply_hop_control ctl (
    .clk(clk), .rstN(rstN), .belowMin(belowMin), .aboveMax(aboveMax), .sel(sel)
  );

  supply_hop_thermo #(.NUM_SW(NUM_SW)) th (
    .count(switchCount), .en(switchEn)
  );

  // R2: count stays within one and the switch total
  a_r2_count_range: assert property (@(posedge clk) disable iff (!rstN)
    (switchCount >= CW'(1)) && (switchCount <= CW'(NUM_SW)));

  // R6: enables form a thermometer code whose population is the count
  a_r6_thermo_shape: assert property (@(posedge clk) disable iff (!rstN)
    (($countones(switchEn) == int'(switchCount)) &&
     ((switchEn & (switchEn + NUM_SW'(1))) == '0)));

endmodule

// File: tb/supply_hop_ctrl_test.sv
`timescale 1ns/1ps
module supply_hop_ctrl_test;

  localparam int NSW = 16;
  localparam int VW  = 10;
  localparam int GW  = 12;
  localparam int FBD = 1;
  localparam int ERD = 1;
  localparam int D   = FBD + ERD;
  localparam int CW  = $clog2(NSW + 1);

  logic clk = 1'b0;
  logic rstN;
  logic [VW-1:0] vCore, vRef;
  logic signed [GW-1:0] gainDiff, gainErr;
  logic [CW-1:0] switchCount;
  logic [NSW-1:0] switchEn;

  supply_hop_ctrl #(.NUM_SW(NSW), .V_W(VW), .GAIN_W(GW), .FRAC(8),
                    .FB_DLY(FBD), .ERR_DLY(ERD)) uut (
    .clk(clk), .rstN(rstN), .vCore(vCore), .vRef(vRef),
    .gainDiff(gainDiff), .gainErr(gainErr),
    .switchCount(switchCount), .switchEn(switchEn)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int expQ[$];
  string tagQ[$];
  int eh[0:7];
  int uh[0:7];

  function automatic logic [NSW-1:0] thermo(int c);
    logic [NSW-1:0] v = '0;
    for (int i = 0; i < NSW; i++) v[i] = (i < c);
    return v;
  endfunction

  function automatic int roundAway(int t);
    if (t >= 0) return (t + 128) / 256;
    return -((-t + 128) / 256);
  endfunction

  task automatic compare(int expCnt, string tag);
    nChecks++;
    if (int'(switchCount) != expCnt) begin
      nFails++;
      $display("FAIL %s count=%0d expected %0d", tag, switchCount, expCnt);
    end
    nChecks++;
    if (switchEn !== thermo(expCnt)) begin
      nFails++;
      $display("FAIL %s/R6 enable=%b expected %b", tag, switchEn, thermo(expCnt));
    end
  endtask

  // Driver: applies one sample and queues the count expected after the next edge
  task automatic step(int vr, int vc, int k1, int k2, string tag);
    int e, a, b, t, nu;
    vRef = VW'(vr); vCore = VW'(vc);
    gainDiff = GW'(k1); gainErr = GW'(k2);
    e = vr - vc;                                   // R4
    a = (D == 0) ? e : eh[D-1];
    b = eh[D];
    if (D == 0) b = eh[0];
    t = k1 * (a - b) + k2 * a;
    nu = uh[FBD-1] + roundAway(t);                 // R3, R5
    if (nu < 1) nu = 1;                            // R8
    if (nu > NSW) nu = NSW;                        // R9
    for (int j = 7; j > 0; j--) begin eh[j] = eh[j-1]; uh[j] = uh[j-1]; end
    eh[0] = e; uh[0] = nu;
    expQ.push_back(nu); tagQ.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: pops and compares shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      int c;
      string tg;
      c = expQ.pop_front();
      tg = tagQ.pop_front();
      compare(c, tg);
    end
  end

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int seed;
    rstN = 1'b0; vRef = '0; vCore = '0; gainDiff = '0; gainErr = '0;
    for (int j = 0; j < 8; j++) begin eh[j] = 0; uh[j] = 1; end
    repeat (3) @(negedge clk);
    compare(1, "R1");                              // reset state
    rstN = 1'b1;

    // R1: zero history and zero error keep one switch on
    for (int i = 0; i < 4; i++) step(500, 500, -317, 56, "R1");

    // R7: positive error step reaches the count after D edges
    step(510, 500, 0, 256, "R7");
    step(510, 500, 0, 256, "R7");
    step(510, 500, 0, 256, "R4");
    for (int i = 0; i < 3; i++) step(510, 500, 0, 256, "R9");

    // R8: large negative error drives to the floor
    for (int i = 0; i < 5; i++) step(400, 500, 0, 256, "R8");

    // R5: halfway values round away from zero
    for (int i = 0; i < 6; i++) step(503, 500, 0, 128, "R5");
    for (int i = 0; i < 6; i++) step(497, 500, 0, 128, "R5");
    for (int i = 0; i < 4; i++) step(501, 500, 0, 128, "R5");
    for (int i = 0; i < 4; i++) step(499, 500, 0, 128, "R5");
    for (int i = 0; i < 4; i++) step(501, 500, 0, 102, "R5");

    // R3: difference term acts once on an error step
    for (int i = 0; i < 4; i++) step(500, 500, 256, 0, "R3");
    for (int i = 0; i < 5; i++) step(505, 500, 256, 0, "R3");
    for (int i = 0; i < 4; i++) step(502, 500, 256, 0, "R3");

    // R9 / R8: extreme codes and gains
    for (int i = 0; i < 4; i++) step(1023, 0, 2047, 2047, "R9");
    for (int i = 0; i < 4; i++) step(0, 1023, 2047, 2047, "R8");
    for (int i = 0; i < 3; i++) step(1023, 0, -2048, -2048, "R8");

    // R2: varying core code with representative gains
    seed = 7;
    for (int i = 0; i < 80; i++) begin
      seed = seed * 1103515245 + 12345;
      step(500, 470 + ((seed >>> 16) & 63), -317, 56, "R2");
    end
    for (int i = 0; i < 40; i++) begin
      seed = seed * 1103515245 + 12345;
      step(520, 490 + ((seed >>> 16) & 31), 64, 200, "R2");
    end

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule